// File: doc/BRIEF.md
# Per-Row Retention-Aware Refresh Scheduler

This block replaces blanket periodic refresh of a DRAM bank with refreshes aimed at single rows. Each row has a retention bin, stored as a 4-bit threshold, and a 4-bit countdown counter. Both live in small on-chip arrays. A global tick starts a sweep that visits one row per clock. Each visited counter steps down by one. A counter that runs out is reloaded from the row's threshold, and the row is placed in a short pending queue. The command issuer turns each queued row into an activate followed by a precharge.

Ordinary reads and writes restore the contents of the row they touch, so the scheduler watches that traffic and reloads the counter of the accessed row. This postpones the row's next refresh. An optional skip mode thins out refreshes of rows in the longest-retention bin, issuing only one out of every four of their expiries. The request toward the command issuer is offered only while all banks report precharged, and it is held until the issuer acknowledges it.

Top module: `rra_refresh_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rfsh_req` is 0. Every counter, threshold and skip phase resets to 0.
- R2: A write on the threshold-load port (`thr_load`, `thr_row`, `thr_val`) sets that row's threshold and also sets its counter to the same value at that clock edge. It takes priority over every other update of that row in the same cycle.
- R3: A `tick` seen while no sweep is running starts a sweep. The sweep visits rows 0 to ROWS-1 on consecutive clocks, one row per clock, starting on the cycle after the tick. A `tick` that arrives while a sweep is running is ignored.
- R4: A visited row whose counter is 1 or 0 has expired. Its counter is reloaded from its threshold and its row number is appended to the pending queue. A visited row with a larger counter is decremented by one.
- R5: When `acc_valid` is high, the counter of `acc_row` is reloaded from its threshold. If that row is the row being visited by the sweep in that same cycle, the access wins: the row is neither decremented nor queued.
- R6: `rfsh_req` is high exactly when the queue is not empty and `banks_idle` is 1. `rfsh_row` shows the oldest queued row, and rows leave the queue in the order they entered. An entry is removed only on a clock where both `rfsh_req` and `rfsh_ack` are high.
- R7: With `skip_en` high, a row whose threshold is 15 (all ones) has a 2-bit phase that advances on each of its expiries. The row is queued only when that phase was 0, which is 1 of every 4 expiries, but its counter is reloaded every time. Rows with other thresholds, and all rows when `skip_en` is low, are queued on every expiry and their phase does not move.
- R8: When QDEPTH entries are already pending, an expiry that should be queued is not consumed. The counter and the phase stay unchanged, so the row expires again on the next sweep. No entry is lost or overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Global retention tick; starts a sweep |
| skip_en | input | 1 | Enables thinning of top-bin refreshes |
| thr_load | input | 1 | Threshold write strobe (profiling result) |
| thr_row | input | ROW_W | Row whose threshold is written |
| thr_val | input | CNT_W | Threshold value |
| acc_valid | input | 1 | A normal read or write opened a row |
| acc_row | input | ROW_W | Row opened by that access |
| banks_idle | input | 1 | All banks are precharged |
| rfsh_req | output | 1 | Row refresh (activate then precharge) requested |
| rfsh_row | output | ROW_W | Row to refresh |
| rfsh_ack | input | 1 | Issuer accepts the current request |

## Verification
The bench aims at four corner cases. The first is an access that lands on the very row the sweep is visiting. A design that let the sweep win would decrement or queue a row that was just restored. The second is a full queue. A design that consumed the expiry anyway would silently drop a refresh, and the bench would see that row never requested. The third is skip mode on top-bin rows. A wrong phase rule would send too many or too few requests for threshold-15 rows, and the counts would drift from the model's one-in-four. The fourth is `banks_idle` toggling while a request is held, along with ticks that arrive mid-sweep. A design that ignored the idle gate, or that restarted the sweep, would show a request in the wrong cycle or a counter off by one tick.

// File: rtl/rra_pkg.sv
package rra_pkg;
  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;

  // expiry: counter has one tick or less left
  function automatic logic is_due(input cnt_t c);
    return (c <= cnt_t'(1));
  endfunction

  // value written back to a visited row
  function automatic cnt_t next_count(input cnt_t c, input cnt_t thr);
    return is_due(c) ? thr : cnt_t'(c - cnt_t'(1));
  endfunction

  function automatic logic is_top_bin(input cnt_t thr);
    return (thr == '1);
  endfunction
endpackage

// File: rtl/rra_row_store.sv
module rra_row_store
  import rra_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] vis_row,
  output cnt_t             vis_cnt,
  output cnt_t             vis_thr,
  output logic [1:0]       vis_ph,
  input  logic             sw_we,
  input  cnt_t             sw_cnt,
  input  logic             ph_we,
  input  logic             acc_we,
  input  logic [ROW_W-1:0] acc_row,
  input  logic             thr_we,
  input  logic [ROW_W-1:0] thr_row,
  input  cnt_t             thr_val
);
  cnt_t       cnt_q [ROWS];
  cnt_t       thr_q [ROWS];
  logic [1:0] ph_q  [ROWS];

  assign vis_cnt = cnt_q[vis_row];
  assign vis_thr = thr_q[vis_row];
  assign vis_ph  = ph_q[vis_row];

  // later writes take priority: sweep < access < threshold load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) begin
        cnt_q[i] <= '0;
        thr_q[i] <= '0;
        ph_q[i]  <= '0;
      end
    end else begin
      if (sw_we)  cnt_q[vis_row] <= sw_cnt;
      if (ph_we)  ph_q[vis_row]  <= vis_ph + 2'd1;
      if (acc_we) cnt_q[acc_row] <= thr_q[acc_row];
      if (thr_we) begin
        thr_q[thr_row] <= thr_val;
        cnt_q[thr_row] <= thr_val;
      end
    end
  end

  p_thr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |=> (thr_q[$past(thr_row)] == $past(thr_val)) &&
               (cnt_q[$past(thr_row)] == $past(thr_val)));
endmodule

// File: rtl/rra_pend_fifo.sv
module rra_pend_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : PW'(p + PW'(1));
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign head  = mem_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push) begin
        mem_q[wr_q] <= din;
        wr_q        <= wrap_inc(wr_q);
      end
      if (pop) rd_q <= wrap_inc(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> $stable(head));
endmodule

// File: rtl/rra_refresh_sched.sv
module rra_refresh_sched
  import rra_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int QDEPTH = 4,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             skip_en,
  input  logic             thr_load,
  input  logic [ROW_W-1:0] thr_row,
  input  logic [CNT_W-1:0] thr_val,
  input  logic             acc_valid,
  input  logic [ROW_W-1:0] acc_row,
  input  logic             banks_idle,
  output logic             rfsh_req,
  output logic [ROW_W-1:0] rfsh_row,
  input  logic             rfsh_ack
);
  logic             busy_q;
  logic [ROW_W-1:0] idx_q;
  cnt_t             vis_cnt, vis_thr;
  logic [1:0]       vis_ph;

  // named internal events
  logic visit_evt, collide_evt, due_evt, gated_evt, issue_evt;
  logic push_evt, consume_evt, pop_evt, sw_we, ph_we;
  logic q_empty, q_full;

  assign visit_evt   = busy_q;
  assign collide_evt = visit_evt && acc_valid && (acc_row == idx_q);
  assign due_evt     = visit_evt && !collide_evt && is_due(vis_cnt);
  assign gated_evt   = skip_en && is_top_bin(vis_thr);
  assign issue_evt   = !gated_evt || (vis_ph == 2'd0);
  assign push_evt    = due_evt && issue_evt && !q_full;
  assign consume_evt = due_evt && (!issue_evt || !q_full);
  assign sw_we       = visit_evt && !collide_evt && (!due_evt || consume_evt);
  assign ph_we       = consume_evt && gated_evt;

  assign rfsh_req = !q_empty && banks_idle;
  assign pop_evt  = rfsh_req && rfsh_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q) begin
      idx_q <= ROW_W'(idx_q + ROW_W'(1));
      if (idx_q == ROW_W'(ROWS - 1)) busy_q <= 1'b0;
    end else if (tick) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end
  end

  rra_row_store #(.ROWS(ROWS), .ROW_W(ROW_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .vis_row (idx_q),
    .vis_cnt (vis_cnt),
    .vis_thr (vis_thr),
    .vis_ph  (vis_ph),
    .sw_we   (sw_we),
    .sw_cnt  (next_count(vis_cnt, vis_thr)),
    .ph_we   (ph_we),
    .acc_we  (acc_valid),
    .acc_row (acc_row),
    .thr_we  (thr_load),
    .thr_row (thr_row),
    .thr_val (thr_val)
  );

  rra_pend_fifo #(.DEPTH(QDEPTH), .W(ROW_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_evt),
    .din   (idx_q),
    .pop   (pop_evt),
    .head  (rfsh_row),
    .empty (q_empty),
    .full  (q_full)
  );

  p_idle_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |-> banks_idle);
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && !rfsh_ack) |=> $stable(rfsh_row));
  p_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    collide_evt |-> !push_evt && !sw_we);
  p_push_in_sweep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |-> busy_q);
  p_skip_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && skip_en && is_top_bin(vis_thr)) |-> (vis_ph == 2'd0));
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (due_evt && issue_evt && q_full) |-> !sw_we && !ph_we);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !rfsh_req);
endmodule

// File: tb/sim_rra_refresh_sched.sv
module sim_rra_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 16;
  localparam int QD   = 4;
  localparam int RW   = $clog2(ROWS);

  logic clk = 0, rst_n = 0;
  logic tick = 0, skip_en = 0, thr_load = 0, acc_valid = 0, banks_idle = 0, rfsh_ack = 0;
  logic [RW-1:0] thr_row = '0, acc_row = '0;
  logic [3:0] thr_val = '0;
  logic rfsh_req;
  logic [RW-1:0] rfsh_row;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference
  int m_cnt [ROWS];
  int m_thr [ROWS];
  int m_ph  [ROWS];
  int m_q [$];
  bit m_busy;
  int m_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  rra_refresh_sched #(.ROWS(ROWS), .QDEPTH(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .skip_en(skip_en),
    .thr_load(thr_load), .thr_row(thr_row), .thr_val(thr_val),
    .acc_valid(acc_valid), .acc_row(acc_row), .banks_idle(banks_idle),
    .rfsh_req(rfsh_req), .rfsh_row(rfsh_row), .rfsh_ack(rfsh_ack));

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) begin m_cnt[i] = 0; m_thr[i] = 0; m_ph[i] = 0; end
      m_q.delete(); m_busy = 0; m_idx = 0;
    end else begin
      bit room;
      room = (m_q.size() < QD);
      if (m_q.size() > 0 && banks_idle && rfsh_ack) void'(m_q.pop_front());
      if (m_busy) begin
        int r;
        r = m_idx;
        if (!(acc_valid && acc_row == r)) begin
          if (m_cnt[r] <= 1) begin
            bit thin, go;
            thin = skip_en && (m_thr[r] == 15);
            go = !thin || (m_ph[r] == 0);
            if (!go || room) begin
              if (go) m_q.push_back(r);
              m_cnt[r] = m_thr[r];
              if (thin) m_ph[r] = (m_ph[r] + 1) % 4;
            end
          end else m_cnt[r] = m_cnt[r] - 1;
        end
        m_idx++;
        if (m_idx == ROWS) begin m_busy = 0; m_idx = 0; end
      end else if (tick) begin
        m_busy = 1; m_idx = 0;
      end
      if (acc_valid) m_cnt[acc_row] = m_thr[acc_row];
      if (thr_load) begin m_thr[thr_row] = thr_val; m_cnt[thr_row] = thr_val; end
    end
  end

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d (cycle %0d)", tag, what, got, exp, cycles);
    end
  endtask

  task automatic compare();
    int ev;
    ev = (m_q.size() > 0 && banks_idle) ? 1 : 0;
    check("rfsh_req", int'(rfsh_req), ev);
    if (ev == 1) check("rfsh_row", int'(rfsh_row), m_q[0]);
  endtask

  // n cycles; percentages for each random input
  task automatic run(input string t, input int n, input int tick_p, input int acc_p,
                     input int ack_p, input int idle_p, input bit skip,
                     input bit aim, input int ld_p);
    tag = t;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare();
      skip_en    = skip;
      tick       = ($urandom_range(99) < tick_p);
      banks_idle = ($urandom_range(99) < idle_p);
      rfsh_ack   = ($urandom_range(99) < ack_p);
      acc_valid  = ($urandom_range(99) < acc_p);
      acc_row    = (aim && m_busy) ? RW'(m_idx) : RW'($urandom_range(ROWS-1));
      thr_load   = ($urandom_range(99) < ld_p);
      thr_row    = RW'($urandom_range(ROWS-1));
      thr_val    = 4'($urandom_range(15));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("rfsh_req in reset R1", int'(rfsh_req), 0);
    rst_n = 1;
    @(negedge clk);
    check("rfsh_req after reset R1", int'(rfsh_req), 0);
    // R2: profile load, mixed bins with several top-bin rows
    tag = "R2";
    for (int r = 0; r < ROWS; r++) begin
      thr_load = 1; thr_row = RW'(r);
      thr_val = (r % 4 == 0) ? 4'd15 : 4'((r % 5) + 1);
      @(negedge clk);
      compare();
    end
    thr_load = 0;
    run("R4", 2000, 10, 0, 80, 90, 0, 0, 0);
    run("R3", 1500, 100, 0, 70, 80, 0, 0, 0);
    run("R5", 2000, 15, 60, 80, 90, 0, 1, 0);
    run("R6", 2000, 15, 20, 40, 50, 0, 0, 0);
    run("R7", 3000, 15, 5, 90, 95, 1, 0, 0);
    run("R8", 2000, 60, 5, 5, 30, 0, 0, 0);
    run("R2", 2000, 15, 20, 60, 80, 1, 0, 10);
    run("R7", 2000, 20, 0, 90, 95, 1, 0, 0);
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d expected end before 150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule